// File: doc/BRIEF.md
# ADC Calibration Phase Sequencer

This controller sequences the trim phases of a successive-approximation converter's calibration. Three events can start a run: the host sets a start bit in a small control register, an active-low calibration pin is released, or the pin stays high for a settling interval after power-on. A 2-bit kind field selects which phases run. The sequencer walks through those phases in a fixed order. Each phase lasts a set number of master-clock cycles, and during it the sequencer raises that phase's enable strobe and presents the code the trim should aim for.

The analog trim hardware sits outside this block. It sees the sequencer only through the three strobes, the target code and the self/system flag. A run reports `busy` from the trigger to the end of the last phase. A one-cycle `done` marks the finish.

The state machine has four states: IDLE, DAC_TRIM, GAIN_TRIM and OFFSET_TRIM. Its transitions are:
- **launch**: IDLE to the entry phase of the selected kind.
- **dac_to_gain**: DAC_TRIM to GAIN_TRIM.
- **gain_to_offset**: GAIN_TRIM to OFFSET_TRIM, for every kind except gain-only.
- **gain_finish**: GAIN_TRIM to IDLE, for gain-only.
- **offset_finish**: OFFSET_TRIM to IDLE.

The last three transitions fire when the phase timer expires.

Top module: `adc_cal_sequencer`

## Requirements
- R1: The kind field selects the phases and their order. Code 00 runs DAC, then gain, then offset. Code 01 runs gain, then offset. Code 10 runs offset only. Code 11 runs gain only.
- R2: Each phase is active for exactly its own cycle count: DAC_CYC, GAIN_CYC or OFF_CYC.
- R3: The `phase` output reads 00 when idle, 01 for DAC, 10 for gain and 11 for offset. Exactly the strobe that matches the active phase is high, and no strobe is high when idle.
- R4: A control-register write with `cfg_start`=1 sets `start_pending`. That bit reads 1 for one cycle and clears as the first phase begins on the next cycle. A write with `cfg_start`=0 only stores the kind and system fields.
- R5: The calibration pin is synchronised through two flops. A run starts only on the pin's release from low to high, three cycles after release. Holding the pin low starts nothing.
- R6: `busy` is high from the trigger until the last phase ends. While `busy` is high, register writes and pin releases are dropped: no run is queued and the stored fields do not change.
- R7: `done` is high for exactly one cycle, the cycle right after the last phase, and `busy` is low in that cycle.
- R8: After reset, once the synchronised pin has been high for POR_CYC cycles, one full self calibration starts. It starts in sample cycle POR_CYC after reset release and happens only once.
- R9: `trim_target` is all ones during the gain phase. During the offset phase it is the midscale code (only the MSB set) if `bipolar` was high at launch, and zero otherwise. It is zero in all other states.
- R10: `system_mode` shows the self (0) or system (1) flag captured at launch while a phase runs. The power-on run always uses kind 00 and self mode, whatever the register holds.
- R11: During and after reset, `busy`, `done`, `phase`, all strobes and `start_pending` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_n | input | 1 | Active-low calibration pin, asynchronous |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_start | input | 1 | Start bit of the write data |
| cfg_kind | input | 2 | Calibration kind of the write data |
| cfg_system | input | 1 | System (1) or self (0) flag of the write data |
| bipolar | input | 1 | Input mode, sampled at launch |
| busy | output | 1 | Calibration pending or running |
| done | output | 1 | One-cycle end-of-run pulse |
| phase | output | 2 | Current phase code |
| dac_trim_en | output | 1 | DAC trim strobe |
| gain_trim_en | output | 1 | Gain trim strobe |
| offset_trim_en | output | 1 | Offset trim strobe |
| trim_target | output | CODE_W | Code the active trim aims for |
| system_mode | output | 1 | Captured self/system flag while running |
| start_pending | output | 1 | Readback of the self-clearing start bit |

## Verification
Some properties are checked by assertions on every cycle:
- the strobes are one-hot and agree with the phase code;
- the legal successors of the DAC and offset states;
- the single-cycle `done` and the fact that `busy` can only fall alongside it;
- the self-clearing start bit;
- the single power-on firing;
- register fields staying unchanged when a write arrives while busy.

Other properties can only be shown by the bench's scenarios. These are the exact phase order and length for every kind, self/system and input-mode combination; the three-cycle latency of a pin release; the cycle at which the power-on run starts; the forced kind and mode of that run; and the fact that a dropped trigger leaves no run behind it.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [1:0] {
        KIND_FULL     = 2'b00,
        KIND_GAIN_OFF = 2'b01,
        KIND_OFF      = 2'b10,
        KIND_GAIN     = 2'b11
    } cal_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_DAC    = 2'b01,
        PH_GAIN   = 2'b10,
        PH_OFFSET = 2'b11
    } cal_phase_e;

    // Entry phase of a run for each kind.
    function automatic cal_phase_e entry_phase(cal_kind_e k);
        cal_phase_e p;
        unique case (k)
            KIND_FULL:     p = PH_DAC;
            KIND_GAIN_OFF: p = PH_GAIN;
            KIND_OFF:      p = PH_OFFSET;
            KIND_GAIN:     p = PH_GAIN;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cal_pin_sync.sv
module cal_pin_sync #(
    parameter int POR_CYC = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_n,
    output logic release_pulse,
    output logic por_fire
);
    localparam int PW = $clog2(POR_CYC + 1);

    logic       s1_q, s2_q, s3_q;
    logic [PW-1:0] por_cnt_q;
    logic       por_done_q;

    // Two-flop synchroniser plus one history flop for edge detection.
    // All three flops reset to the released (high) level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= cal_n;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign release_pulse = s2_q & ~s3_q;
    assign por_fire      = s2_q & ~por_done_q & (por_cnt_q == PW'(POR_CYC - 1));

    // Power-on settling counter: restarts whenever the pin is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por_cnt_q  <= '0;
            por_done_q <= 1'b0;
        end else if (!s2_q) begin
            por_cnt_q <= '0;
        end else if (!por_done_q) begin
            if (por_fire) por_done_q <= 1'b1;
            else          por_cnt_q  <= por_cnt_q + 1'b1;
        end
    end

    // R5
    release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> !release_pulse);

    // R8
    por_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_fire |=> (!por_fire && por_done_q));

endmodule

// File: rtl/cal_ctrl_reg.sv
module cal_ctrl_reg
    import cal_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic      wr_start,
    input  cal_kind_e wr_kind,
    input  logic      wr_sys,
    input  logic      busy,
    input  logic      launch,
    output logic      start_q,
    output cal_kind_e kind_q,
    output logic      sys_q
);
    logic accept;

    assign accept = wr & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            kind_q  <= KIND_FULL;
            sys_q   <= 1'b0;
        end else begin
            if (accept) begin
                kind_q  <= wr_kind;
                sys_q   <= wr_sys;
                start_q <= wr_start;
            end else if (launch) begin
                start_q <= 1'b0;
            end
        end
    end

    // R4
    start_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

    // R6
    busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr) |=> ($stable(kind_q) && $stable(sys_q)));

endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer
    import cal_seq_pkg::*;
#(
    parameter int DAC_CYC  = 194640,
    parameter int GAIN_CYC = 27780,
    parameter int OFF_CYC  = 27780
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  cal_phase_e load_phase,
    output logic       expire
);
    localparam int MAX_AB  = (DAC_CYC > GAIN_CYC) ? DAC_CYC : GAIN_CYC;
    localparam int MAX_LEN = (MAX_AB > OFF_CYC) ? MAX_AB : OFF_CYC;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload;

    always_comb begin
        unique case (load_phase)
            PH_DAC:    reload = CW'(DAC_CYC - 1);
            PH_GAIN:   reload = CW'(GAIN_CYC - 1);
            PH_OFFSET: reload = CW'(OFF_CYC - 1);
            PH_IDLE:   reload = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= reload;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_LEN - 1));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expire) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import cal_seq_pkg::*;
#(
    parameter int DAC_CYC  = 194640,
    parameter int GAIN_CYC = 27780,
    parameter int OFF_CYC  = 27780,
    parameter int POR_CYC  = 600000,
    parameter int CODE_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_n,
    input  logic              cfg_wr,
    input  logic              cfg_start,
    input  logic [1:0]        cfg_kind,
    input  logic              cfg_system,
    input  logic              bipolar,
    output logic              busy,
    output logic              done,
    output logic [1:0]        phase,
    output logic              dac_trim_en,
    output logic              gain_trim_en,
    output logic              offset_trim_en,
    output logic [CODE_W-1:0] trim_target,
    output logic              system_mode,
    output logic              start_pending
);
    localparam logic [CODE_W-1:0] MID_CODE  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] TOP_CODE  = '1;
    localparam logic [CODE_W-1:0] ZERO_CODE = '0;

    logic       pin_release, por_fire, start_q, cfg_sys_q;
    cal_kind_e  cfg_kind_q, sel_kind, run_kind_q;
    logic       sel_sys, run_sys_q, run_bip_q;
    cal_phase_e state_q, state_d;
    logic       launch, phase_expire, timer_load, done_q;

    cal_pin_sync #(.POR_CYC(POR_CYC)) u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .cal_n         (cal_n),
        .release_pulse (pin_release),
        .por_fire      (por_fire)
    );

    cal_ctrl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wr_start (cfg_start),
        .wr_kind  (cal_kind_e'(cfg_kind)),
        .wr_sys   (cfg_system),
        .busy     (busy),
        .launch   (launch),
        .start_q  (start_q),
        .kind_q   (cfg_kind_q),
        .sys_q    (cfg_sys_q)
    );

    cal_phase_timer #(
        .DAC_CYC  (DAC_CYC),
        .GAIN_CYC (GAIN_CYC),
        .OFF_CYC  (OFF_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (timer_load),
        .load_phase (state_d),
        .expire     (phase_expire)
    );

    // Trigger arbitration: power-on run forces a full self calibration.
    always_comb begin
        sel_kind = por_fire ? KIND_FULL : cfg_kind_q;
        sel_sys  = por_fire ? 1'b0 : cfg_sys_q;
        launch   = (state_q == PH_IDLE) && (start_q || pin_release || por_fire);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (launch)       state_d = entry_phase(sel_kind);
            PH_DAC:    if (phase_expire) state_d = PH_GAIN;
            PH_GAIN:   if (phase_expire) state_d = (run_kind_q == KIND_GAIN) ? PH_IDLE : PH_OFFSET;
            PH_OFFSET: if (phase_expire) state_d = PH_IDLE;
        endcase
    end

    assign timer_load = (state_d != state_q) && (state_d != PH_IDLE);

    // State register and run context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= PH_IDLE;
            run_kind_q <= KIND_FULL;
            run_sys_q  <= 1'b0;
            run_bip_q  <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != PH_IDLE) && (state_d == PH_IDLE);
            if (launch) begin
                run_kind_q <= sel_kind;
                run_sys_q  <= sel_sys;
                run_bip_q  <= bipolar;
            end
        end
    end

    // Outputs.
    always_comb begin
        dac_trim_en    = 1'b0;
        gain_trim_en   = 1'b0;
        offset_trim_en = 1'b0;
        trim_target    = ZERO_CODE;
        unique case (state_q)
            PH_IDLE:   ;
            PH_DAC:    dac_trim_en = 1'b1;
            PH_GAIN: begin
                gain_trim_en = 1'b1;
                trim_target  = TOP_CODE;
            end
            PH_OFFSET: begin
                offset_trim_en = 1'b1;
                trim_target    = run_bip_q ? MID_CODE : ZERO_CODE;
            end
        endcase
    end

    assign phase         = state_q;
    assign busy          = (state_q != PH_IDLE) | start_q;
    assign done          = done_q;
    assign system_mode   = run_sys_q & (state_q != PH_IDLE);
    assign start_pending = start_q;

    // R3
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dac_trim_en, gain_trim_en, offset_trim_en})
        && ((phase == 2'b00) == !(dac_trim_en | gain_trim_en | offset_trim_en)));

    // R1
    dac_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DAC) |=> (state_q == PH_DAC || state_q == PH_GAIN));

    // R1
    offset_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_OFFSET) |=> (state_q == PH_OFFSET || state_q == PH_IDLE));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    gain_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_trim_en |-> (trim_target == TOP_CODE));

endmodule

// File: tb/sim_adc_cal_sequencer.sv
module sim_adc_cal_sequencer;
    localparam int DAC_CYC  = 7;
    localparam int GAIN_CYC = 4;
    localparam int OFF_CYC  = 3;
    localparam int POR_CYC  = 20;
    localparam int CODE_W   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_n = 1'b1;
    logic cfg_wr = 1'b0, cfg_start = 1'b0, cfg_system = 1'b0, bipolar = 1'b0;
    logic [1:0] cfg_kind = 2'b00;
    logic busy, done, dac_trim_en, gain_trim_en, offset_trim_en, system_mode, start_pending;
    logic [1:0] phase;
    logic [CODE_W-1:0] trim_target;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    adc_cal_sequencer #(
        .DAC_CYC(DAC_CYC), .GAIN_CYC(GAIN_CYC), .OFF_CYC(OFF_CYC),
        .POR_CYC(POR_CYC), .CODE_W(CODE_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cal_n(cal_n), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
        .cfg_kind(cfg_kind), .cfg_system(cfg_system), .bipolar(bipolar), .busy(busy),
        .done(done), .phase(phase), .dac_trim_en(dac_trim_en), .gain_trim_en(gain_trim_en),
        .offset_trim_en(offset_trim_en), .trim_target(trim_target),
        .system_mode(system_mode), .start_pending(start_pending)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int phase_len(int p);
        return (p == 1) ? DAC_CYC : (p == 2) ? GAIN_CYC : OFF_CYC;
    endfunction

    // Observe a run from the current sample until busy drops.
    task automatic watch(input int k, input bit s, input bit b);
        int seq[3];
        int lens[3];
        int exp_seq[3];
        int n = 0;
        int last = 0;
        int guard = 0;
        int exp_n;
        while (busy && guard < 400) begin
            if (phase != 2'b00) begin
                int tgt;
                if (int'(phase) != last) begin
                    if (n < 3) begin seq[n] = int'(phase); lens[n] = 0; end
                    n++;
                    last = int'(phase);
                end
                if (n <= 3) lens[n-1]++;
                chk({dac_trim_en, gain_trim_en, offset_trim_en} ==
                    {phase == 2'd1, phase == 2'd2, phase == 2'd3}, "R3 strobes",
                    int'({dac_trim_en, gain_trim_en, offset_trim_en}), int'(phase));
                tgt = (phase == 2'd2) ? 255 : (phase == 2'd3 && b) ? 128 : 0;
                chk(int'(trim_target) == tgt, "R9 target", int'(trim_target), tgt);
                chk(system_mode == s, "R10 system_mode", int'(system_mode), int'(s));
            end
            @(negedge clk);
            guard++;
        end
        case (k)
            0: begin exp_n = 3; exp_seq = '{1, 2, 3}; end
            1: begin exp_n = 2; exp_seq = '{2, 3, 0}; end
            2: begin exp_n = 1; exp_seq = '{3, 0, 0}; end
            default: begin exp_n = 1; exp_seq = '{2, 0, 0}; end
        endcase
        chk(n == exp_n, "R1 phase count", n, exp_n);
        for (int i = 0; i < exp_n && i < n && i < 3; i++) begin
            chk(seq[i] == exp_seq[i], "R1 phase order", seq[i], exp_seq[i]);
            chk(lens[i] == phase_len(exp_seq[i]), "R2 phase length", lens[i], phase_len(exp_seq[i]));
        end
        chk(done == 1'b1, "R7 done at end", int'(done), 1);
        chk(busy == 1'b0, "R7 busy low with done", int'(busy), 0);
        chk(phase == 2'b00 && trim_target == '0, "R9 idle target", int'(trim_target), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single", int'(done), 0);
    endtask

    task automatic reg_launch(input int k, input bit s, input bit b);
        bipolar = b; cfg_kind = 2'(k); cfg_system = s; cfg_start = 1'b1; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_start = 1'b0;
        chk(start_pending == 1'b1, "R4 start set", int'(start_pending), 1);
        chk(busy == 1'b1, "R6 busy from trigger", int'(busy), 1);
        chk(phase == 2'b00, "R4 pending cycle idle", int'(phase), 0);
        @(negedge clk);
        chk(start_pending == 1'b0, "R4 self-clear", int'(start_pending), 0);
        watch(k, s, b);
    endtask

    task automatic write_cfg(input int k, input bit s);
        cfg_kind = 2'(k); cfg_system = s; cfg_start = 1'b0; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(busy == 1'b0 && start_pending == 1'b0, "R4 write without start", int'(busy), 0);
    endtask

    task automatic pin_launch(input int k, input bit s, input bit b);
        bipolar = b;
        cal_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R5 held low idle", int'(busy), 0);
        end
        cal_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R5 sync delay 1", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b0, "R5 sync delay 2", int'(busy), 0);
        @(negedge clk);
        chk(busy == 1'b1, "R5 release starts run", int'(busy), 1);
        watch(k, s, b);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && phase == 0 && start_pending == 0, "R11 reset outputs",
            int'({busy, done, phase, start_pending}), 0);
        chk({dac_trim_en, gain_trim_en, offset_trim_en} == 3'b000, "R11 reset strobes",
            int'({dac_trim_en, gain_trim_en, offset_trim_en}), 0);
        rst_n = 1'b1;

        // R8 power-on run; the register holds gain-only/system, which must be overridden (R10)
        for (int i = 1; i < POR_CYC; i++) begin
            @(negedge clk);
            if (i == 5) begin
                cfg_kind = 2'b11; cfg_system = 1'b1; cfg_wr = 1'b1;
            end else begin
                cfg_wr = 1'b0;
            end
            chk(busy == 1'b0, "R8 no early start", int'(busy), 0);
        end
        @(negedge clk);
        chk(busy == 1'b1 && phase == 2'b01, "R8 power-on start cycle", int'(phase), 1);
        watch(0, 1'b0, 1'b0);

        // R8 no second power-on run
        for (int i = 0; i < POR_CYC + 5; i++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R8 single power-on run", int'(busy), 0);
        end

        // R5 pin uses the stored fields (gain-only, system)
        pin_launch(3, 1'b1, 1'b1);

        // R1 R2 R9 R10 sweep through the register path
        for (int k = 0; k < 4; k++)
            for (int s = 0; s < 2; s++)
                for (int b = 0; b < 2; b++)
                    reg_launch(k, 1'(s), 1'(b));

        // R5 sweep through the pin path
        for (int k = 0; k < 4; k++) begin
            write_cfg(k, 1'(k & 1));
            pin_launch(k, 1'(k & 1), 1'(k >> 1));
        end

        // R6 triggers during a run are dropped and fields stay unchanged
        write_cfg(0, 1'b0);
        bipolar = 1'b1; cfg_start = 1'b1; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_start = 1'b0;
        @(negedge clk);
        cfg_kind = 2'b10; cfg_system = 1'b1; cfg_start = 1'b1; cfg_wr = 1'b1; cal_n = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_start = 1'b0;
        @(negedge clk);
        cal_n = 1'b1;
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        chk(done == 1'b1, "R6 run completes", int'(done), 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(busy == 1'b0 && start_pending == 1'b0, "R6 dropped trigger", int'(busy), 0);
        end
        pin_launch(0, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule